// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block turns up to eight asynchronous interrupt pins into clean, software-controlled interrupt requests. Each pin goes through a synchroniser and then an event detector. The detector reacts to one of five sense modes: a rising edge, a falling edge, both edges, a low level or a high level. A detected event latches a per-pin request flag. Software reads the flags back and clears them by writing zero to the bits it wants gone.

Each pin drives its own interrupt output. That output is gated by a mask bit and by a 4-bit priority field. The priority field works only as a coarse on/off switch: zero blocks the pin and any other value lets it through. The mask bit has no read-write register. It is set through one write-only address and cleared through another. A combined output is the OR of all per-pin outputs.

Pin 0 always sits at the most significant end of each register. In the sense and priority words, pin n owns bits (7-n)*4+3 down to (7-n)*4. In the flag, mask-set and mask-clear words, pin n owns bit FLAG_WIDTH-1-n, where FLAG_WIDTH is 8 or 32. Software uses a plain register bus: a write strobe, a 3-bit word address and 32-bit write data. Read data depends combinationally on the address.

Top module: `xpin_irq_ctrl`

## Requirements
- R1: After reset, every sense field and priority field reads 0, the flag word reads 0, every pin is masked, and all interrupt outputs are low.
- R2: Address 0 is the sense word and address 1 is the priority word. Pin n's 4-bit field sits at bit (7-n)*4, so pin 0 is in bits 31:28. Both words read back what was written.
- R3: Sense code 1 latches a request on a rising pin edge and code 0 on a falling edge. The flag becomes readable after the third rising clock edge following the pin change, and not after the second.
- R4: Sense code 4 latches a request on either edge. Codes 5 to 15 never latch a request.
- R5: Sense code 2 (low level) and code 3 (high level) keep setting the request while the level is active. A clearing write has no effect until the pin goes inactive, and takes effect after that.
- R6: The flag word at address 2 holds pin n's request at bit FLAG_WIDTH-1-n. A write clears each request whose bit is written 0 and leaves each bit written 1 unchanged.
- R7: Writing address 3 masks each pin whose bit (FLAG_WIDTH-1-n) is 1. Bits written 0 have no effect. The address reads as 0.
- R8: Writing address 4 unmasks each pin whose bit (FLAG_WIDTH-1-n) is 1. Bits written 0 have no effect. The address reads as 0.
- R9: irq_o[n] is high exactly when pin n's request is set, pin n is unmasked and pin n's priority field is nonzero. irq_any_o is the OR of all irq_o bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Asynchronous interrupt pins, index = pin number |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_o | output | NUM_PINS | Per-pin gated interrupt outputs |
| irq_any_o | output | 1 | OR of all per-pin outputs |

## Verification
The bench sweeps all sixteen sense codes on every pin and drives a rise and then a fall on each. A detector that mixes up the polarities, or that lets an unused code trigger, latches the wrong flag. A flag that shows up one cycle early exposes a synchroniser that is too short. Level modes get a clearing write while the level is still active and another after it drops. A design that lets the clear win over a live level shows a missing flag, and one that keeps re-setting after the drop shows a stuck flag. All 256 flag-write patterns and all 256 mask-clear patterns are applied. A reversed bit order, or a set/clear port that touches bits written 0, then shows up as wrong flag or interrupt bits.

// File: rtl/xpin_pkg.sv
package xpin_pkg;
   localparam int MAX_PINS = 8;
   localparam int FIELD_W  = 4;
   localparam int WORD_W   = 32;
   localparam int ADDR_W   = 3;

   typedef enum logic [FIELD_W-1:0] {
      SENSE_FALL = 4'd0,
      SENSE_RISE = 4'd1,
      SENSE_LOW  = 4'd2,
      SENSE_HIGH = 4'd3,
      SENSE_BOTH = 4'd4
   } sense_e;

   typedef enum logic [ADDR_W-1:0] {
      REG_SENSE = 3'd0,
      REG_PRIO  = 3'd1,
      REG_FLAG  = 3'd2,
      REG_MSET  = 3'd3,
      REG_MCLR  = 3'd4
   } reg_e;

   // pin 0 owns the most significant field of a 32-bit field word
   function automatic int field_lsb(input int pin);
      return (MAX_PINS - 1 - pin) * FIELD_W;
   endfunction
endpackage

// File: rtl/xpin_sync.sv
module xpin_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_i,
   output logic q_o
);
   if (STAGES < 2) begin : g_bad_stages
      $error("xpin_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i};
   end

   assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/xpin_detect.sv
module xpin_detect
   import xpin_pkg::*;
(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               lvl_i,
   input  logic [FIELD_W-1:0] mode_i,
   output logic               evt_o
);
   logic prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl_i;
   end

   always_comb begin
      case (sense_e'(mode_i))
         SENSE_FALL: evt_o = prev_q & ~lvl_i;
         SENSE_RISE: evt_o = lvl_i & ~prev_q;
         SENSE_LOW:  evt_o = ~lvl_i;
         SENSE_HIGH: evt_o = lvl_i;
         SENSE_BOTH: evt_o = lvl_i ^ prev_q;
         default:    evt_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/xpin_pin.sv
module xpin_pin
   import xpin_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               pin_i,
   input  logic [FIELD_W-1:0] mode_i,
   input  logic               drop_i,
   output logic               evt_o,
   output logic               req_o
);
   logic lvl;
   logic req_q;

   xpin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (pin_i),
      .q_o   (lvl)
   );

   xpin_detect u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl),
      .mode_i (mode_i),
      .evt_o  (evt_o)
   );

   // a fresh event outranks a clearing write in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) req_q <= 1'b0;
      else        req_q <= evt_o | (req_q & ~drop_i);
   end

   assign req_o = req_q;
endmodule

// File: rtl/xpin_regs.sv
module xpin_regs
   import xpin_pkg::*;
#(
   parameter int NUM_PINS   = 8,
   parameter int FLAG_WIDTH = 8
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              wr_i,
   input  logic [ADDR_W-1:0]                 addr_i,
   input  logic [WORD_W-1:0]                 wdata_i,
   input  logic [NUM_PINS-1:0]               req_i,
   output logic [WORD_W-1:0]                 rdata_o,
   output logic [NUM_PINS-1:0][FIELD_W-1:0]  mode_o,
   output logic [NUM_PINS-1:0]               prio_on_o,
   output logic [NUM_PINS-1:0]               mask_o,
   output logic [NUM_PINS-1:0]               drop_o
);
   logic [NUM_PINS-1:0][FIELD_W-1:0] sense_q;
   logic [NUM_PINS-1:0][FIELD_W-1:0] prio_q;
   logic [NUM_PINS-1:0]              mask_q;
   logic [WORD_W-1:0]                sense_word;
   logic [WORD_W-1:0]                prio_word;
   logic [FLAG_WIDTH-1:0]            flag_word;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sense_q <= '0;
         prio_q  <= '0;
         mask_q  <= '1;
      end else if (wr_i) begin
         for (int n = 0; n < NUM_PINS; n++) begin
            case (reg_e'(addr_i))
               REG_SENSE: sense_q[n] <= wdata_i[field_lsb(n) +: FIELD_W];
               REG_PRIO:  prio_q[n]  <= wdata_i[field_lsb(n) +: FIELD_W];
               REG_MSET:  if (wdata_i[FLAG_WIDTH-1-n]) mask_q[n] <= 1'b1;
               REG_MCLR:  if (wdata_i[FLAG_WIDTH-1-n]) mask_q[n] <= 1'b0;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      sense_word = '0;
      prio_word  = '0;
      flag_word  = '0;
      for (int n = 0; n < NUM_PINS; n++) begin
         sense_word[field_lsb(n) +: FIELD_W] = sense_q[n];
         prio_word[field_lsb(n) +: FIELD_W]  = prio_q[n];
         flag_word[FLAG_WIDTH-1-n]           = req_i[n];
         drop_o[n]    = wr_i && (addr_i == REG_FLAG) && !wdata_i[FLAG_WIDTH-1-n];
         prio_on_o[n] = |prio_q[n];
      end
   end

   always_comb begin
      case (reg_e'(addr_i))
         REG_SENSE: rdata_o = sense_word;
         REG_PRIO:  rdata_o = prio_word;
         REG_FLAG:  rdata_o = WORD_W'(flag_word);
         default:   rdata_o = '0;
      endcase
   end

   assign mode_o = sense_q;
   assign mask_o = mask_q;
endmodule

// File: rtl/xpin_irq_ctrl.sv
module xpin_irq_ctrl
   import xpin_pkg::*;
#(
   parameter int NUM_PINS    = 8,
   parameter int FLAG_WIDTH  = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PINS-1:0] pin_i,
   input  logic                bus_wr,
   input  logic [ADDR_W-1:0]   bus_addr,
   input  logic [WORD_W-1:0]   bus_wdata,
   output logic [WORD_W-1:0]   bus_rdata,
   output logic [NUM_PINS-1:0] irq_o,
   output logic                irq_any_o
);
   if (NUM_PINS < 1 || NUM_PINS > MAX_PINS) begin : g_bad_pins
      $error("xpin_irq_ctrl: NUM_PINS out of range 1..8");
   end
   if (FLAG_WIDTH != 8 && FLAG_WIDTH != 32) begin : g_bad_flag
      $error("xpin_irq_ctrl: FLAG_WIDTH must be 8 or 32");
   end

   logic [NUM_PINS-1:0][FIELD_W-1:0] mode;
   logic [NUM_PINS-1:0]              prio_on;
   logic [NUM_PINS-1:0]              mask_vec;
   logic [NUM_PINS-1:0]              drop_vec;
   logic [NUM_PINS-1:0]              req_vec;
   logic [NUM_PINS-1:0]              evt_vec;

   xpin_regs #(.NUM_PINS(NUM_PINS), .FLAG_WIDTH(FLAG_WIDTH)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_i      (bus_wr),
      .addr_i    (bus_addr),
      .wdata_i   (bus_wdata),
      .req_i     (req_vec),
      .rdata_o   (bus_rdata),
      .mode_o    (mode),
      .prio_on_o (prio_on),
      .mask_o    (mask_vec),
      .drop_o    (drop_vec)
   );

   for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
      xpin_pin #(.SYNC_STAGES(SYNC_STAGES)) u_pin (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin_i  (pin_i[n]),
         .mode_i (mode[n]),
         .drop_i (drop_vec[n]),
         .evt_o  (evt_vec[n]),
         .req_o  (req_vec[n])
      );
      assign irq_o[n] = req_vec[n] & ~mask_vec[n] & prio_on[n];
   end

   assign irq_any_o = |irq_o;
endmodule

// File: rtl/xpin_irq_ctrl_chk.sv
module xpin_irq_ctrl_chk
   import xpin_pkg::*;
#(
   parameter int NUM_PINS   = 8,
   parameter int FLAG_WIDTH = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [ADDR_W-1:0]   bus_addr,
   input logic [WORD_W-1:0]   bus_wdata,
   input logic [WORD_W-1:0]   bus_rdata,
   input logic [NUM_PINS-1:0] irq_o,
   input logic [NUM_PINS-1:0] req,
   input logic [NUM_PINS-1:0] mask,
   input logic [NUM_PINS-1:0] evt
);
   logic [NUM_PINS-1:0] wbit;
   logic wr_flag, wr_mset, wr_mclr;

   always_comb begin
      for (int n = 0; n < NUM_PINS; n++) wbit[n] = bus_wdata[FLAG_WIDTH-1-n];
   end
   assign wr_flag = bus_wr && (bus_addr == REG_FLAG);
   assign wr_mset = bus_wr && (bus_addr == REG_MSET);
   assign wr_mclr = bus_wr && (bus_addr == REG_MCLR);

   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (req == '0 && mask == '1));

   assert_event_latches_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt) |=> ((req & $past(evt)) == $past(evt)));

   assert_zero_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_flag |=> ((req & ~$past(wbit) & ~$past(evt)) == '0));

   assert_req_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_flag |=> ((req & $past(req)) == $past(req)));

   assert_mask_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mset |=> ((mask & $past(wbit)) == $past(wbit)));

   assert_mask_steady_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_mset || wr_mclr) |=> (mask == $past(mask)));

   assert_mask_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_mclr |=> ((mask & $past(wbit)) == '0));

   assert_wo_reads_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == REG_MSET || bus_addr == REG_MCLR) |-> (bus_rdata == '0));

   assert_masked_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_o & mask) == '0));
endmodule

bind xpin_irq_ctrl xpin_irq_ctrl_chk #(.NUM_PINS(NUM_PINS), .FLAG_WIDTH(FLAG_WIDTH)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_wr    (bus_wr),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_o     (irq_o),
   .req       (req_vec),
   .mask      (mask_vec),
   .evt       (evt_vec)
);

// File: tb/xpin_irq_ctrl_tb.sv
module xpin_irq_ctrl_tb;
   localparam int NP = 8;
   localparam int FW = 8;
   localparam logic [2:0] A_SENSE = 3'd0, A_PRIO = 3'd1, A_FLAG = 3'd2,
                          A_MSET = 3'd3, A_MCLR = 3'd4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NP-1:0] pin_i = '0;
   logic          bus_wr = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic [NP-1:0] irq_o;
   logic          irq_any_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   xpin_irq_ctrl u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_i     (pin_i),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_o     (irq_o),
      .irq_any_o (irq_any_o)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   function automatic logic [7:0] rev8(input logic [7:0] v);
      for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
   endfunction

   function automatic logic [31:0] flagbit(input int p, input bit on);
      return on ? (32'd1 << (FW-1-p)) : 32'd0;
   endfunction

   initial begin
      logic [31:0] v;
      string tag;
      tick(3);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      rd(A_SENSE, v); check("R1 sense", v, 0);
      rd(A_PRIO, v);  check("R1 prio", v, 0);
      rd(A_FLAG, v);  check("R1 flag", v, 0);
      check("R1 irq", {24'd0, irq_o}, 0);
      check("R1 any", {31'd0, irq_any_o}, 0);

      // R2 field layout read-back
      wr(A_SENSE, 32'h1234_5678);
      rd(A_SENSE, v); check("R2 sense", v, 32'h1234_5678);
      wr(A_PRIO, 32'h9ABC_DEF0);
      rd(A_PRIO, v);  check("R2 prio", v, 32'h9ABC_DEF0);
      check("R1 masked after reset", {24'd0, irq_o}, 0);
      wr(A_SENSE, 0);
      wr(A_PRIO, 0);
      wr(A_FLAG, 0);
      rd(A_FLAG, v); check("R6 clear all", v, 0);

      // R3 R4 R5 sweep of every pin and sense code
      for (int p = 0; p < NP; p++) begin
         for (int m = 0; m < 16; m++) begin
            tag = (m < 2) ? "R3" : (m < 4) ? "R5" : "R4";
            wr(A_SENSE, 32'(m) << ((7-p)*4));
            wr(A_FLAG, 0);
            rd(A_FLAG, v); check($sformatf("%s p%0d m%0d idle-low", tag, p, m), v, flagbit(p, m == 2));
            pin_i[p] = 1'b1;
            tick(2);
            rd(A_FLAG, v); check($sformatf("R3 p%0d m%0d latency", p, m), v, flagbit(p, m == 2));
            tick(1);
            rd(A_FLAG, v); check($sformatf("%s p%0d m%0d rise", tag, p, m), v, flagbit(p, m >= 1 && m <= 4));
            wr(A_FLAG, 0);
            rd(A_FLAG, v); check($sformatf("R5 p%0d m%0d clr-high", p, m), v, flagbit(p, m == 3));
            pin_i[p] = 1'b0;
            tick(3);
            rd(A_FLAG, v); check($sformatf("%s p%0d m%0d fall", tag, p, m), v,
                                 flagbit(p, m == 0 || m == 2 || m == 3 || m == 4));
            wr(A_FLAG, 0);
            rd(A_FLAG, v); check($sformatf("R5 p%0d m%0d clr-low", p, m), v, flagbit(p, m == 2));
            wr(A_SENSE, 0);
            wr(A_FLAG, 0);
         end
      end

      // R6 every flag-write pattern
      wr(A_SENSE, 32'h1111_1111);
      for (int w = 0; w < 256; w++) begin
         pin_i = '0;
         tick(3);
         pin_i = '1;
         tick(3);
         rd(A_FLAG, v); check("R6 all set", v, 32'hFF);
         wr(A_FLAG, 32'(w));
         rd(A_FLAG, v); check($sformatf("R6 write %02h", w), v, 32'(w));
         wr(A_FLAG, 32'hFF);
         rd(A_FLAG, v); check("R6 ones keep", v, 32'(w));
         wr(A_FLAG, 0);
      end
      pin_i = '0;
      tick(3);
      rd(A_FLAG, v); check("R3 fall ignored in rise mode", v, 0);

      // R7 R8 R9 gating
      wr(A_SENSE, 32'h3333_3333);
      pin_i = '1;
      wr(A_PRIO, 32'hFFFF_FFFF);
      tick(3);
      rd(A_FLAG, v); check("R5 all high", v, 32'hFF);
      check("R1 still masked", {24'd0, irq_o}, 0);
      check("R1 any masked", {31'd0, irq_any_o}, 0);
      wr(A_MCLR, 32'hFF); check("R8 unmask all", {24'd0, irq_o}, 32'hFF);
      check("R9 any", {31'd0, irq_any_o}, 1);
      wr(A_MSET, 32'hA0); check("R7 mask pins 0,2", {24'd0, irq_o}, 32'hFA);
      wr(A_MSET, 32'h00); check("R7 zeros no effect", {24'd0, irq_o}, 32'hFA);
      wr(A_MCLR, 32'h20); check("R8 unmask pin 2", {24'd0, irq_o}, 32'hFE);
      wr(A_MCLR, 32'h00); check("R8 zeros no effect", {24'd0, irq_o}, 32'hFE);
      rd(A_MSET, v); check("R7 reads zero", v, 0);
      rd(A_MCLR, v); check("R8 reads zero", v, 0);
      wr(A_PRIO, 32'h0F0F_0F0F);
      check("R9 prio gate", {24'd0, irq_o}, 32'hAA);
      for (int w = 0; w < 256; w++) begin
         logic [7:0] e;
         wr(A_MSET, 32'hFF);
         wr(A_MCLR, 32'(w));
         e = rev8(8'(w)) & 8'hAA;
         check($sformatf("R9 irq mask %02h", w), {24'd0, irq_o}, {24'd0, e});
         check($sformatf("R9 any mask %02h", w), {31'd0, irq_any_o}, {31'd0, |e});
      end
      wr(A_MCLR, 32'hFF);
      wr(A_PRIO, 0);
      check("R9 prio zero", {24'd0, irq_o}, 0);
      check("R9 prio zero any", {31'd0, irq_any_o}, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end
endmodule